// File: doc/BRIEF.md
# Layered Min-Sum Check Node Processor

This block carries out the check-node step of a layered LDPC decoder for one layer at a time. Soft-output values arrive one per cycle, each paired with the message that this check node sent to that variable on the previous pass. For each arrival the block forms the variable-to-check message by subtraction. It keeps the two smallest magnitudes, the position of the smallest and the parity of the signs, and it stores the message. Once the last edge of the layer has arrived, it plays the edges back in their arrival order. For each edge it emits a new check-to-variable message from a normalized min-sum rule and the updated soft output.

Each edge has a write-disable flag. A flagged edge still produces values at the outputs, but both write strobes stay low, so the soft-output memory and the message memory keep their old contents. A layer that holds a double-diagonal sub-matrix can then be processed twice. The surrounding control disables one diagonal on each pass, and both diagonals end up contributing. The layer length is given at run time with the start-of-layer marker. The soft-output memory is loaded with the channel LLRs and the message memory is cleared to zero before decoding starts; both lie outside this block.

Top module: `ldpc_minsum_np`

## Requirements
- R1: While reset is asserted and just after it is released, `out_valid`, `out_so_we` and `out_msg_we` are 0 and `in_ready` is 1.
- R2: For each edge the variable-to-check value is `in_so - in_c2v_old`, computed without overflow. The emitted `out_so` is that value plus `out_c2v`, clamped to the signed range of `out_so`.
- R3: The magnitude of `out_c2v` for edge i is m - floor(m/4). Here m is the smallest variable-to-check magnitude among the other edges of the layer, each magnitude first clamped to 2^(MSG_W-1)-1. If the layer has a single edge, m is that clamp value.
- R4: `out_c2v` for edge i is negative exactly when an odd number of the other edges have a negative variable-to-check value. A value of zero counts as non-negative. When two edges share the smallest magnitude, each receives that magnitude.
- R5: `out_c2v` never has a magnitude larger than C - floor(C/4), where C = 2^(MSG_W-1)-1. It never takes the most negative code.
- R6: Results leave in arrival order, one per cycle. The first result is valid on the second rising edge after the edge that accepts the layer's last input, and exactly one result is produced per edge of the layer. The layer length `in_deg` is taken from the start-of-layer input and may be 1 to MAX_DEG.
- R7: For an edge accepted with `in_wdis` = 1, both `out_so_we` and `out_msg_we` are 0 while its result is valid. For other edges both are 1. Both are 0 whenever `out_valid` is 0.
- R8: `in_ready` is 0 from the cycle after a layer's last input until its last result is presented. Inputs offered while `in_ready` is 0 have no effect on any result.
- R9: An input with `in_valid` = 1 and `in_first` = 0 while no layer is open is ignored. An input with `in_first` = 1 during collection discards the partial layer and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An edge is offered this cycle |
| in_first | input | 1 | The offered edge is the first of a layer |
| in_deg | input | DEG_W | Edges in the layer, sampled with `in_first` |
| in_so | input | SO_W | Current soft output of the edge's variable (signed) |
| in_c2v_old | input | MSG_W | Previous check-to-variable message of the edge (signed) |
| in_wdis | input | 1 | Suppress both memory writes for this edge |
| in_ready | output | 1 | Block accepts edges |
| out_valid | output | 1 | Result for one edge is present |
| out_so | output | SO_W | Updated soft output (signed) |
| out_c2v | output | MSG_W | New check-to-variable message (signed) |
| out_so_we | output | 1 | Write strobe for the soft-output memory |
| out_msg_we | output | 1 | Write strobe for the message memory |

## Verification
A corrupted minimum, minimum position or sign parity shows up in the first result of the affected layer. Every edge reads those registers, so the whole run of `out_c2v` values is wrong as soon as playback begins, two cycles after the last input. A wrong entry in the edge store affects only the matching result, in both `out_so` and the strobes, which is why every edge of every layer is compared. A counter or state error shows as a wrong number of results, as a bad `in_ready` window, or as stray inputs being accepted. The next layer then differs from the reference model.

// File: rtl/ldpc_np_pkg.sv
package ldpc_np_pkg;

  // Controller phases: waiting for a layer, gathering edges, replaying them.
  typedef enum logic [1:0] {
    NP_IDLE    = 2'd0,
    NP_COLLECT = 2'd1,
    NP_EMIT    = 2'd2
  } np_state_e;

endpackage

// File: rtl/np_v2c_unit.sv
// Forms the variable-to-check value of one edge with its clamped magnitude and sign.
module np_v2c_unit #(
  parameter int SO_W  = 8,
  parameter int MSG_W = 6
) (
  input  logic signed [SO_W-1:0]  so_i,
  input  logic signed [MSG_W-1:0] c2v_i,
  output logic signed [SO_W:0]    v2c_o,
  output logic [MSG_W-2:0]        mag_o,
  output logic                    neg_o
);
  localparam int VW = SO_W + 1;
  localparam logic [VW-1:0] MAG_CAP = VW'((1 << (MSG_W - 1)) - 1);

  logic [VW-1:0] abs_v;

  always_comb begin
    v2c_o = {so_i[SO_W-1], so_i} - {{(VW - MSG_W){c2v_i[MSG_W-1]}}, c2v_i};
    neg_o = v2c_o[VW-1];
    abs_v = neg_o ? VW'(-v2c_o) : VW'(v2c_o);
    mag_o = (abs_v > MAG_CAP) ? MAG_CAP[MSG_W-2:0] : abs_v[MSG_W-2:0];
  end
endmodule

// File: rtl/np_min_track.sv
// Running two-minimum search with position of the smallest and sign parity.
module np_min_track #(
  parameter int MW = 5,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [MW-1:0] mag,
  input  logic          neg,
  input  logic [IW-1:0] idx,
  output logic [MW-1:0] min1,
  output logic [MW-1:0] min2,
  output logic [IW-1:0] idx1,
  output logic          sgn
);
  logic [MW-1:0] b1, b2, n1, n2;
  logic [IW-1:0] bi, ni;
  logic          bs, ns;

  always_comb begin
    b1 = clr ? '1 : min1;
    b2 = clr ? '1 : min2;
    bi = clr ? '0 : idx1;
    bs = clr ? 1'b0 : sgn;
    n1 = b1;
    n2 = b2;
    ni = bi;
    ns = bs ^ neg;
    if (mag < b1) begin
      n1 = mag;
      n2 = b1;
      ni = idx;
    end else if (mag < b2) begin
      n2 = mag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min1 <= '1;
      min2 <= '1;
      idx1 <= '0;
      sgn  <= 1'b0;
    end else if (en) begin
      min1 <= n1;
      min2 <= n2;
      idx1 <= ni;
      sgn  <= ns;
    end
  end
endmodule

// File: rtl/np_edge_buf.sv
// Per-edge store of the variable-to-check value and the write-disable flag.
module np_edge_buf #(
  parameter int VW    = 9,
  parameter int DEPTH = 32,
  parameter int IW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [VW-1:0] wv2c,
  input  logic          wwd,
  input  logic [IW-1:0] raddr,
  output logic [VW-1:0] rv2c,
  output logic          rwd
);
  logic [VW-1:0] v2c_q [DEPTH];
  logic          wd_q  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = we && (waddr == IW'(g));
    always_ff @(posedge clk) begin
      if (slot_en) begin
        v2c_q[g] <= wv2c;
        wd_q[g]  <= wwd;
      end
    end
  end

  always_comb begin
    rv2c = v2c_q[raddr];
    rwd  = wd_q[raddr];
  end
endmodule

// File: rtl/np_out_calc.sv
// Normalized min-sum message and soft-output update for one replayed edge.
module np_out_calc #(
  parameter int SO_W  = 8,
  parameter int MSG_W = 6,
  parameter int IW    = 5
) (
  input  logic signed [SO_W:0]    v2c,
  input  logic [IW-1:0]           ridx,
  input  logic [MSG_W-2:0]        min1,
  input  logic [MSG_W-2:0]        min2,
  input  logic [IW-1:0]           idx1,
  input  logic                    sgn,
  output logic signed [MSG_W-1:0] c2v_new,
  output logic signed [SO_W-1:0]  so_new
);
  localparam int MW = MSG_W - 1;
  localparam int SW = SO_W + 2;
  localparam logic signed [SW-1:0] SO_MAX = SW'((1 << (SO_W - 1)) - 1);
  localparam logic signed [SW-1:0] SO_MIN = -SW'(1 << (SO_W - 1));

  logic [MW-1:0]          m_sel, m_scl;
  logic                   out_neg;
  logic signed [SW-1:0]   sum;

  always_comb begin
    m_sel   = (ridx == idx1) ? min2 : min1;
    m_scl   = m_sel - (m_sel >> 2);
    out_neg = sgn ^ v2c[SO_W];
    c2v_new = out_neg ? -$signed({1'b0, m_scl}) : $signed({1'b0, m_scl});
    sum     = SW'(v2c) + SW'(c2v_new);
    if (sum > SO_MAX)      so_new = SO_MAX[SO_W-1:0];
    else if (sum < SO_MIN) so_new = SO_MIN[SO_W-1:0];
    else                   so_new = sum[SO_W-1:0];
  end
endmodule

// File: rtl/ldpc_minsum_np.sv
module ldpc_minsum_np
  import ldpc_np_pkg::*;
#(
  parameter int SO_W    = 8,
  parameter int MSG_W   = 6,
  parameter int MAX_DEG = 32,
  parameter int DEG_W   = $clog2(MAX_DEG + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_first,
  input  logic [DEG_W-1:0]        in_deg,
  input  logic signed [SO_W-1:0]  in_so,
  input  logic signed [MSG_W-1:0] in_c2v_old,
  input  logic                    in_wdis,
  output logic                    in_ready,
  output logic                    out_valid,
  output logic signed [SO_W-1:0]  out_so,
  output logic signed [MSG_W-1:0] out_c2v,
  output logic                    out_so_we,
  output logic                    out_msg_we
);
  localparam int IW = (MAX_DEG > 1) ? $clog2(MAX_DEG) : 1;
  localparam int VW = SO_W + 1;
  localparam int MW = MSG_W - 1;
  localparam int CW = DEG_W + 1;

  np_state_e        state_q, state_d;
  logic [IW-1:0]    cnt_q, cnt_d;
  logic [DEG_W-1:0] deg_q, deg_d;

  logic             accept, emit, wlast, elast;
  logic [IW-1:0]    widx;
  logic [DEG_W-1:0] deg_lim, layer_deg;

  logic signed [VW-1:0] v2c_in, v2c_rd;
  logic [MW-1:0]        mag_in, min1, min2;
  logic                 neg_in, sgn, wd_rd;
  logic [IW-1:0]        idx1;
  logic signed [MSG_W-1:0] c2v_calc;
  logic signed [SO_W-1:0]  so_calc;

  logic                    ov_q, we_q;
  logic signed [SO_W-1:0]  oso_q;
  logic signed [MSG_W-1:0] oc2v_q;

  // Input acceptance and per-layer bookkeeping
  always_comb begin
    in_ready = (state_q != NP_EMIT);
    accept   = in_valid && in_ready && (in_first || state_q == NP_COLLECT);
    emit     = (state_q == NP_EMIT);
    if (in_deg == '0)                    deg_lim = DEG_W'(1);
    else if (in_deg > DEG_W'(MAX_DEG))   deg_lim = DEG_W'(MAX_DEG);
    else                                 deg_lim = in_deg;
    widx      = in_first ? '0 : cnt_q;
    layer_deg = in_first ? deg_lim : deg_q;
    wlast     = (CW'(widx) + CW'(1)) == CW'(layer_deg);
    elast     = (CW'(cnt_q) + CW'(1)) == CW'(deg_q);
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    deg_d   = deg_q;
    case (state_q)
      NP_IDLE, NP_COLLECT: begin
        if (accept) begin
          deg_d = layer_deg;
          if (wlast) begin
            state_d = NP_EMIT;
            cnt_d   = '0;
          end else begin
            state_d = NP_COLLECT;
            cnt_d   = widx + IW'(1);
          end
        end
      end
      NP_EMIT: begin
        if (elast) begin
          state_d = NP_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + IW'(1);
        end
      end
      default: begin
        state_d = NP_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= NP_IDLE;
      cnt_q   <= '0;
      deg_q   <= DEG_W'(1);
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      deg_q   <= deg_d;
    end
  end

  np_v2c_unit #(.SO_W(SO_W), .MSG_W(MSG_W)) i_v2c (
    .so_i(in_so), .c2v_i(in_c2v_old),
    .v2c_o(v2c_in), .mag_o(mag_in), .neg_o(neg_in)
  );

  np_min_track #(.MW(MW), .IW(IW)) i_min (
    .clk(clk), .rst_n(rst_n),
    .clr(accept && in_first), .en(accept),
    .mag(mag_in), .neg(neg_in), .idx(widx),
    .min1(min1), .min2(min2), .idx1(idx1), .sgn(sgn)
  );

  np_edge_buf #(.VW(VW), .DEPTH(MAX_DEG), .IW(IW)) i_buf (
    .clk(clk), .we(accept), .waddr(widx),
    .wv2c(v2c_in), .wwd(in_wdis),
    .raddr(cnt_q), .rv2c(v2c_rd), .rwd(wd_rd)
  );

  np_out_calc #(.SO_W(SO_W), .MSG_W(MSG_W), .IW(IW)) i_calc (
    .v2c(v2c_rd), .ridx(cnt_q),
    .min1(min1), .min2(min2), .idx1(idx1), .sgn(sgn),
    .c2v_new(c2v_calc), .so_new(so_calc)
  );

  // Output register stage, data loaded only while replaying
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q   <= 1'b0;
      we_q   <= 1'b0;
      oso_q  <= '0;
      oc2v_q <= '0;
    end else begin
      ov_q <= emit;
      we_q <= emit && !wd_rd;
      if (emit) begin
        oso_q  <= so_calc;
        oc2v_q <= c2v_calc;
      end
    end
  end

  assign out_valid  = ov_q;
  assign out_so     = oso_q;
  assign out_c2v    = oc2v_q;
  assign out_so_we  = we_q;
  assign out_msg_we = we_q;
endmodule

// File: rtl/ldpc_np_checker.sv
module ldpc_np_checker #(
  parameter int MSG_W   = 6,
  parameter int MAX_DEG = 32,
  parameter int DEG_W   = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_first,
  input logic [DEG_W-1:0]        in_deg,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic signed [MSG_W-1:0] out_c2v,
  input logic                    out_so_we,
  input logic                    out_msg_we
);
  localparam int CAP   = (1 << (MSG_W - 1)) - 1;
  localparam int SCMAX = CAP - (CAP >> 2);

  logic [DEG_W:0] lat_deg, ocnt;
  logic           start;

  assign start = in_valid && in_first && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_deg <= '0;
      ocnt    <= '0;
    end else if (start) begin
      ocnt <= '0;
      if (in_deg == '0)                  lat_deg <= (DEG_W+1)'(1);
      else if (in_deg > DEG_W'(MAX_DEG)) lat_deg <= (DEG_W+1)'(MAX_DEG);
      else                               lat_deg <= (DEG_W+1)'(in_deg);
    end else if (out_valid) begin
      ocnt <= ocnt + 1'b1;
    end
  end

  // R7: strobes only accompany a valid result
  a_r7_strobe_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_so_we && !out_msg_we));

  // R5: message magnitude bounded by the scaled clamp
  a_r5_msg_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_c2v) <= SCMAX && $signed(out_c2v) >= -SCMAX));

  // R8: playback starts only after input was blocked
  a_r8_busy_before_output: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !$past(in_ready));

  // R6: no more results than edges in the layer
  a_r6_result_count: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (ocnt < lat_deg));
endmodule

bind ldpc_minsum_np ldpc_np_checker #(.MSG_W(MSG_W), .MAX_DEG(MAX_DEG), .DEG_W(DEG_W)) i_np_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
  .in_deg(in_deg), .in_ready(in_ready), .out_valid(out_valid),
  .out_c2v(out_c2v), .out_so_we(out_so_we), .out_msg_we(out_msg_we)
);

// File: tb/test_ldpc_minsum_np.sv
`timescale 1ns/1ps
module test_ldpc_minsum_np;
  localparam int SO_W = 8, MSG_W = 6, MAX_DEG = 32, DEG_W = 6;
  localparam int CAP = 31;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_first, in_wdis;
  logic [DEG_W-1:0] in_deg;
  logic signed [SO_W-1:0] in_so;
  logic signed [MSG_W-1:0] in_c2v_old;
  logic in_ready, out_valid, out_so_we, out_msg_we;
  logic signed [SO_W-1:0] out_so;
  logic signed [MSG_W-1:0] out_c2v;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  int d_so[MAX_DEG], d_c2v[MAX_DEG];
  bit d_wd[MAX_DEG];
  int e_so[MAX_DEG], e_c2v[MAX_DEG];
  bit e_we[MAX_DEG];

  // Stimulus table: degree, SO base, SO step, message step, write-disable mask
  localparam int NV = 6;
  localparam int T_DEG[NV]   = '{4, 7, 12, 16, 32, 9};
  localparam int T_BASE[NV]  = '{12, -50, 90, 3, -7, 127};
  localparam int T_STEP[NV]  = '{37, 23, -41, 61, 19, -64};
  localparam int T_CSTEP[NV] = '{5, 11, 17, 29, 13, 3};
  localparam logic [31:0] T_WD[NV] = '{32'h0, 32'h12, 32'h0, 32'h8001, 32'hA5A50F0F, 32'h1FF};

  always #4 clk = ~clk;

  ldpc_minsum_np #(.SO_W(SO_W), .MSG_W(MSG_W), .MAX_DEG(MAX_DEG), .DEG_W(DEG_W)) i_ldpc_minsum_np (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_deg(in_deg), .in_so(in_so), .in_c2v_old(in_c2v_old), .in_wdis(in_wdis),
    .in_ready(in_ready), .out_valid(out_valid), .out_so(out_so), .out_c2v(out_c2v),
    .out_so_we(out_so_we), .out_msg_we(out_msg_we)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference: direct min over the other edges per edge
  task automatic model(input int deg);
    int v[MAX_DEG];
    int mg[MAX_DEG];
    for (int i = 0; i < deg; i++) begin
      v[i] = d_so[i] - d_c2v[i];
      mg[i] = (v[i] < 0) ? -v[i] : v[i];
      if (mg[i] > CAP) mg[i] = CAP;
    end
    for (int i = 0; i < deg; i++) begin
      int m = CAP;
      bit s = 0;
      int sc, t;
      for (int j = 0; j < deg; j++) begin
        if (j != i) begin
          if (mg[j] < m) m = mg[j];
          if (v[j] < 0) s = ~s;
        end
      end
      sc = m - m / 4;
      e_c2v[i] = s ? -sc : sc;
      t = v[i] + e_c2v[i];
      if (t > 127) t = 127;
      if (t < -128) t = -128;
      e_so[i] = t;
      e_we[i] = !d_wd[i];
    end
  endtask

  task automatic run_layer(input int deg, input bit junk);
    model(deg);
    for (int i = 0; i < deg; i++) begin
      @(negedge clk);
      chk("R8", "ready while collecting", int'(in_ready), 1);
      in_valid = 1; in_first = (i == 0); in_deg = DEG_W'(deg);
      in_so = SO_W'(d_so[i]); in_c2v_old = MSG_W'(d_c2v[i]); in_wdis = d_wd[i];
    end
    @(negedge clk);
    chk("R8", "ready during playback", int'(in_ready), 0);
    in_valid = junk; in_first = junk; in_deg = 6'd3;
    in_so = 8'sd77; in_c2v_old = -6'sd9; in_wdis = 1'b0;
    for (int k = 0; k < deg; k++) begin
      @(negedge clk);
      if (k >= deg - 1) begin in_valid = 0; in_first = 0; end
      chk("R6", $sformatf("valid edge %0d", k), int'(out_valid), 1);
      chk("R2", $sformatf("so edge %0d", k), int'(out_so), e_so[k]);
      chk("R3", $sformatf("c2v edge %0d", k), int'(out_c2v), e_c2v[k]);
      chk("R7", $sformatf("so_we edge %0d", k), int'(out_so_we), int'(e_we[k]));
      chk("R7", $sformatf("msg_we edge %0d", k), int'(out_msg_we), int'(e_we[k]));
    end
    @(negedge clk);
    chk("R6", "valid after layer", int'(out_valid), 0);
    chk("R7", "strobes idle", int'(out_so_we | out_msg_we), 0);
    chk("R8", "ready after layer", int'(in_ready), 1);
  endtask

  task automatic fill(input int deg, input int so, input int c2v, input bit wd);
    for (int i = 0; i < deg; i++) begin d_so[i] = so; d_c2v[i] = c2v; d_wd[i] = wd; end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL R6 watchdog: actual 0 expected 1 completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_first = 0; in_deg = '0;
    in_so = '0; in_c2v_old = '0; in_wdis = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "valid in reset", int'(out_valid), 0);
    chk("R1", "strobes in reset", int'(out_so_we | out_msg_we), 0);
    chk("R1", "ready in reset", int'(in_ready), 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "valid after reset", int'(out_valid), 0);

    // Table-driven layers
    for (int t = 0; t < NV; t++) begin
      for (int i = 0; i < T_DEG[t]; i++) begin
        int v = (T_BASE[t] + T_STEP[t] * i) & 255;
        d_so[i]  = (v > 127) ? v - 256 : v;
        d_c2v[i] = ((((T_BASE[t] * 3 + T_CSTEP[t] * i) % 63) + 63) % 63) - 31;
        d_wd[i]  = T_WD[t][i];
      end
      run_layer(T_DEG[t], (t % 2) == 1);
    end

    // R3: single-edge layer uses the clamp value
    fill(1, 20, 5, 0);
    run_layer(1, 1);
    chk("R3", "single edge msg", e_c2v[0], 24);

    // R4: tied minima and mixed signs
    fill(3, 10, 0, 0); d_so[1] = -10;
    run_layer(3, 0);
    chk("R4", "tie msg edge0", e_c2v[0], -8);

    // R4: zero variable-to-check counts as non-negative
    fill(4, 6, 6, 0); d_so[2] = -20; d_c2v[2] = 0;
    run_layer(4, 1);

    // R2: positive and negative soft-output saturation
    fill(4, 127, -31, 0);
    run_layer(4, 0);
    fill(5, -128, 31, 1);
    run_layer(5, 1);

    // R7: alternate write-disables over a full-length layer
    for (int i = 0; i < MAX_DEG; i++) begin
      d_so[i] = 40 - 3 * i; d_c2v[i] = (i % 7) - 3; d_wd[i] = i[0];
    end
    run_layer(MAX_DEG, 1);

    // R9: stray edge without an open layer is ignored
    @(negedge clk);
    in_valid = 1; in_first = 0; in_so = -8'sd100; in_c2v_old = 6'sd2; in_deg = 6'd1;
    repeat (2) @(negedge clk);
    in_valid = 0;
    chk("R9", "ready after stray", int'(in_ready), 1);
    @(negedge clk);
    chk("R9", "no output from stray", int'(out_valid), 0);
    fill(2, 15, 3, 0); d_so[1] = 50;
    run_layer(2, 0);

    // R9: restart discards a partial layer
    @(negedge clk);
    in_valid = 1; in_first = 1; in_deg = 6'd4; in_so = -8'sd1; in_c2v_old = 6'sd30; in_wdis = 0;
    @(negedge clk);
    in_first = 0; in_so = -8'sd90;
    fill(3, -33, -4, 0); d_so[2] = 70;
    run_layer(3, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule